// File: doc/BRIEF.md
# Hart Status Register With Machine and Supervisor Views

This unit holds the 64-bit status word of one hart. Two views reach the same storage: a machine view that sees and writes every implemented field, and a supervisor view that sees only a subset and whose writes pass through the machine write path. A write is a single-cycle request made of a view select, write data and an enable. Reads are combinational, and the read port picks the view on its own select.

Writes follow per-field masks, and those masks depend on the machine XLEN input. The two XLEN fields inside the register have WARL behaviour. The user XLEN field takes a new value only when the written value is nonzero. The supervisor XLEN field is rewritten with the machine XLEN on every write while the machine runs wider than 32 bits. The read value carries a dirty-state summary bit, placed for the current machine width.

The block also produces two registered outputs. One is a translation-flush pulse, raised when a write touches a field that affects address translation. The other is the effective user XLEN, recomputed after each write.

Top module: `hart_status_csr`

## Requirements
- R1: In the cycle after reset is released, the machine read returns UXL (bits 33:32) and SXL (bits 35:34) equal to the machine XLEN input, with every other stored bit zero. The XLEN encoding is 1 for 32-bit and 2 for 64-bit. The effective XLEN output equals the machine XLEN and the flush output is 0.
- R2: A machine write stores (old & ~mask) | (data & mask), and the result is visible after the next clock edge. The mask holds MIE[3], SIE[1], MPIE[7], SPIE[5], SPP[8], MPP[12:11], VS[10:9], FS[14:13], MPRV[17], SUM[18], MXR[19], TVM[20], TW[21] and TSR[22].
- R3: MPV[39] and GVA[38] are writable only when the machine XLEN is not 1. When it is 1, writes leave them unchanged.
- R4: When the machine XLEN is not 1, a write whose UXL bits are zero leaves the stored UXL unchanged, and a write with nonzero UXL bits stores them.
- R5: When the machine XLEN is 2, every write sets SXL to the machine XLEN, whatever the data. When it is 1, SXL is not rewritten.
- R6: A supervisor read returns the stored value ANDed with SIE, SPIE, SPP, VS, FS, XS[16:15], SUM and MXR. UXL is also included when the effective XLEN is not 1.
- R7: A supervisor write first merges its data into the stored value under the supervisor read mask. The merged word is then applied as a machine write, so the rules of R2 to R5 still hold. As a result, a supervisor write never changes MPP, MPV or the machine enables.
- R8: The summary bit reads as 1 when FS, VS or XS equals 3. It is bit 63 when the machine XLEN is 2. When the machine XLEN is 1, the read is truncated to 32 bits, the summary bit sits at bit 31 and bits 63:32 read 0.
- R9: The flush output is high for exactly the one cycle after a write whose effective data differs from the stored value in MXR, MPP or MPV. It stays low for every other write and for idle cycles.
- R10: After each write, the effective XLEN output becomes 1 if the machine XLEN is 1, and otherwise the updated UXL value. Between writes it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mxl_i | input | 2 | Machine XLEN (1 = 32-bit, 2 = 64-bit) |
| wr_en_i | input | 1 | Write request, one cycle per write |
| wr_sup_i | input | 1 | Write view: 1 = supervisor, 0 = machine |
| wr_data_i | input | 64 | Write data |
| rd_sup_i | input | 1 | Read view: 1 = supervisor, 0 = machine |
| rd_data_o | output | 64 | Read data of the selected view, summary bit included |
| flush_o | output | 1 | One-cycle translation-flush pulse |
| eff_xl_o | output | 2 | Registered effective user XLEN |

## Verification
The checker watches several rules on every cycle:
- a zero UXL write leaves UXL unchanged;
- SXL is forced after every 64-bit write;
- a supervisor write leaves MPP unchanged;
- MPV and GVA stay frozen in 32-bit mode;
- a flush pulse only ever follows a write;
- the effective XLEN collapses to 32-bit.

Some behaviour is shown only by the bench's scenarios. These are the exact merged values under each mask, the supervisor read mask switching as UXL changes, where the summary bit lands in each width, and the flush staying low on writes that change only fields outside the flush set.

// File: rtl/hart_status_csr.sv
module hart_status_csr #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mxl_i,
  input  logic          wr_en_i,
  input  logic          wr_sup_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_sup_i,
  output logic [DW-1:0] rd_data_o,
  output logic          flush_o,
  output logic [1:0]    eff_xl_o
);
  localparam logic [1:0] XL32 = 2'd1;
  localparam int HW = DW / 2;

  localparam logic [DW-1:0] F_SIE  = DW'(1) << 1;
  localparam logic [DW-1:0] F_MIE  = DW'(1) << 3;
  localparam logic [DW-1:0] F_SPIE = DW'(1) << 5;
  localparam logic [DW-1:0] F_MPIE = DW'(1) << 7;
  localparam logic [DW-1:0] F_SPP  = DW'(1) << 8;
  localparam logic [DW-1:0] F_VS   = DW'(3) << 9;
  localparam logic [DW-1:0] F_MPP  = DW'(3) << 11;
  localparam logic [DW-1:0] F_FS   = DW'(3) << 13;
  localparam logic [DW-1:0] F_XS   = DW'(3) << 15;
  localparam logic [DW-1:0] F_MPRV = DW'(1) << 17;
  localparam logic [DW-1:0] F_SUM  = DW'(1) << 18;
  localparam logic [DW-1:0] F_MXR  = DW'(1) << 19;
  localparam logic [DW-1:0] F_TVM  = DW'(1) << 20;
  localparam logic [DW-1:0] F_TW   = DW'(1) << 21;
  localparam logic [DW-1:0] F_TSR  = DW'(1) << 22;
  localparam logic [DW-1:0] F_UXL  = DW'(3) << 32;
  localparam logic [DW-1:0] F_GVA  = DW'(1) << 38;
  localparam logic [DW-1:0] F_MPV  = DW'(1) << 39;

  localparam logic [DW-1:0] M_BASE = F_SIE | F_MIE | F_SPIE | F_MPIE | F_SPP | F_MPP |
                                     F_VS | F_FS | F_MPRV | F_SUM | F_MXR | F_TVM |
                                     F_TW | F_TSR;
  localparam logic [DW-1:0] S_BASE = F_SIE | F_SPIE | F_SPP | F_VS | F_FS | F_XS |
                                     F_SUM | F_MXR;
  localparam logic [DW-1:0] F_FLUSH = F_MXR | F_MPP | F_MPV;

  logic [DW-1:0] stat_q;
  logic [1:0]    eff_q;
  logic          flush_q;

  logic [DW-1:0] s_mask, m_mask, src, nxt, view;
  logic [1:0]    nxt_eff;
  logic          sd;

  assign s_mask = S_BASE | ((eff_q != XL32) ? F_UXL : '0);
  assign src    = wr_sup_i ? ((stat_q & ~s_mask) | (wr_data_i & s_mask)) : wr_data_i;

  always_comb begin
    m_mask = M_BASE;
    if (mxl_i != XL32) begin
      m_mask = m_mask | F_MPV | F_GVA;
      if ((src & F_UXL) != '0) m_mask = m_mask | F_UXL;
    end
    nxt = (stat_q & ~m_mask) | (src & m_mask);
    if (mxl_i > XL32) nxt[35:34] = mxl_i;
    nxt_eff = (mxl_i == XL32) ? XL32 : nxt[33:32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q         <= '0;
      stat_q[33:32]  <= mxl_i;
      stat_q[35:34]  <= mxl_i;
      eff_q          <= mxl_i;
      flush_q        <= 1'b0;
    end else begin
      flush_q <= wr_en_i && (((stat_q ^ src) & F_FLUSH) != '0);
      if (wr_en_i) begin
        stat_q <= nxt;
        eff_q  <= nxt_eff;
      end
    end
  end

  assign view = rd_sup_i ? (stat_q & s_mask) : stat_q;
  assign sd   = (&stat_q[14:13]) | (&stat_q[10:9]) | (&stat_q[16:15]);
  assign rd_data_o = (mxl_i == XL32) ? {{HW{1'b0}}, sd, view[HW-2:0]}
                                     : {sd, view[DW-2:0]};
  assign flush_o  = flush_q;
  assign eff_xl_o = eff_q;
endmodule

// File: rtl/hart_status_csr_chk.sv
module hart_status_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mxl_i,
  input logic        wr_en_i,
  input logic        wr_sup_i,
  input logic [63:0] wr_data_i,
  input logic [63:0] stat_q,
  input logic        flush_o,
  input logic [1:0]  eff_xl_o
);
  // R4
  uxl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[33:32] == 2'd0) |=> $stable(stat_q[33:32]));

  // R5
  sxl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && mxl_i == 2'd2) |=> (stat_q[35:34] == 2'd2));

  // R7
  sup_mpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sup_i) |=> $stable(stat_q[12:11]));

  // R3
  narrow_mpv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && mxl_i == 2'd1) |=> $stable(stat_q[39:38]));

  // R9
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_o) |-> $past(wr_en_i));

  // R10
  eff_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && mxl_i == 2'd1) |=> (eff_xl_o == 2'd1));
endmodule

bind hart_status_csr hart_status_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mxl_i(mxl_i), .wr_en_i(wr_en_i), .wr_sup_i(wr_sup_i),
  .wr_data_i(wr_data_i), .stat_q(stat_q), .flush_o(flush_o), .eff_xl_o(eff_xl_o)
);

// File: tb/hart_status_csr_test.sv
`timescale 1ns/1ps
module hart_status_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mxl_i = 2'd2;
  logic        wr_en_i = 1'b0;
  logic        wr_sup_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic        rd_sup_i = 1'b0;
  logic [63:0] rd_data_o;
  logic        flush_o;
  logic [1:0]  eff_xl_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hart_status_csr uut (
    .clk(clk), .rst_n(rst_n), .mxl_i(mxl_i), .wr_en_i(wr_en_i), .wr_sup_i(wr_sup_i),
    .wr_data_i(wr_data_i), .rd_sup_i(rd_sup_i), .rd_data_o(rd_data_o),
    .flush_o(flush_o), .eff_xl_o(eff_xl_o)
  );

  typedef struct packed {
    logic        sup;
    logic [63:0] wd;
    logic [63:0] mrd;
    logic [63:0] srd;
    logic        fl;
    logic [1:0]  eff;
  } vec_t;

  // All rows run with machine XLEN = 2, in order, state carried across rows.
  localparam vec_t TBL [8] = '{
    '{1'b0, 64'h0000_0000_0000_1888, 64'h0000_000A_0000_1888, 64'h0000_0002_0000_0000, 1'b1, 2'd2}, // R2 R4 R9
    '{1'b0, 64'h0000_0005_0000_1888, 64'h0000_0009_0000_1888, 64'h0000_0000_0000_0000, 1'b0, 2'd1}, // R4 R5 R6 R10
    '{1'b0, 64'h0000_0002_0000_1888, 64'h0000_000A_0000_1888, 64'h0000_0002_0000_0000, 1'b0, 2'd2}, // R4 R10
    '{1'b1, 64'h0000_0000_0000_0000, 64'h0000_000A_0000_1888, 64'h0000_0002_0000_0000, 1'b0, 2'd2}, // R7 R4
    '{1'b1, 64'h0000_0000_0008_0002, 64'h0000_000A_0008_188A, 64'h0000_0002_0008_0002, 1'b1, 2'd2}, // R7 R9
    '{1'b0, 64'h0000_0082_0008_188A, 64'h0000_008A_0008_188A, 64'h0000_0002_0008_0002, 1'b1, 2'd2}, // R3 R9
    '{1'b0, 64'h0000_0000_0000_6000, 64'h8000_000A_0000_6000, 64'h8000_0002_0000_6000, 1'b1, 2'd2}, // R8 R9
    '{1'b0, 64'h0000_0000_0010_6000, 64'h8000_000A_0010_6000, 64'h8000_0002_0000_6000, 1'b0, 2'd2}  // R9 R6
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sup, input logic [63:0] wd);
    @(negedge clk);
    wr_sup_i  = sup;
    wr_data_i = wd;
    wr_en_i   = 1'b1;
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  task automatic mread(output logic [63:0] v);
    rd_sup_i = 1'b0; #1 v = rd_data_o;
  endtask

  task automatic sread(output logic [63:0] v);
    rd_sup_i = 1'b1; #1 v = rd_data_o; rd_sup_i = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] xl);
    @(negedge clk);
    mxl_i = xl;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    do_reset(2'd2);
    mread(v);
    chk("R1 reset read", v, 64'h0000_000A_0000_0000);
    chk("R1 reset eff", {62'd0, eff_xl_o}, 64'd2);
    chk("R1 reset flush", {63'd0, flush_o}, 64'd0);

    for (int i = 0; i < 8; i++) begin
      do_write(TBL[i].sup, TBL[i].wd);
      chk($sformatf("R9 row%0d flush", i), {63'd0, flush_o}, {63'd0, TBL[i].fl});
      mread(v);
      chk($sformatf("R2 row%0d machine read", i), v, TBL[i].mrd);
      sread(v);
      chk($sformatf("R6 row%0d supervisor read", i), v, TBL[i].srd);
      chk($sformatf("R10 row%0d eff", i), {62'd0, eff_xl_o}, {62'd0, TBL[i].eff});
      @(negedge clk);
      chk($sformatf("R9 row%0d flush drops", i), {63'd0, flush_o}, 64'd0);
    end

    // 32-bit machine width
    do_reset(2'd1);
    mread(v);
    chk("R1 narrow reset read", v, 64'd0);
    chk("R1 narrow reset eff", {62'd0, eff_xl_o}, 64'd1);
    do_write(1'b0, 64'h0000_0080_0000_1800);
    chk("R9 narrow flush on MPP", {63'd0, flush_o}, 64'd1);
    mread(v);
    chk("R2 narrow read", v, 64'h0000_0000_0000_1800);
    chk("R10 narrow eff", {62'd0, eff_xl_o}, 64'd1);
    do_write(1'b0, 64'h0000_0000_0000_6000);
    mread(v);
    chk("R8 summary at bit 31", v, 64'h0000_0000_8000_6000);
    @(negedge clk);
    mxl_i = 2'd2;
    mread(v);
    chk("R3 R5 MPV untouched, SXL kept", v, 64'h8000_0005_0000_6000);
    do_reset(2'd2);

    finish_run();
  end
endmodule